// File: doc/BRIEF.md
# Instruction-Decoding Integer ALU and Shifter

This is a purely combinational execution unit. Each cycle it receives a 32-bit instruction word together with the two source register values, called rs and rt. It decodes the 6-bit major opcode in bits 31:26 and, for register-format words, the 6-bit function code in bits 5:0. From these it produces a 32-bit result and the 5-bit index of the register that should receive it.

The unit covers addition, subtraction, the bitwise logic operations, signed and unsigned set-less-than, and load-upper-immediate. Each of these comes in register-register and 16-bit-immediate flavours. The unit also performs left, logical-right and arithmetic-right shifts of rt. The shift distance comes from the instruction's shift-amount field or from the low five bits of rs.

The unit does not trap on overflow. Any encoding it does not implement raises an illegal flag and forces the result and destination to zero. Register-file access and write-back stay with the surrounding pipeline.

Top module: `int_alu_shift`

## Requirements
- R1: With opcode 000000, function codes 100000 (add), 100001 (add, no trap), 100010 (subtract) and 100011 (subtract, no trap) return rs+rt or rs-rt, wrapped modulo 2^32. Each pair gives identical results.
- R2: With opcode 000000, function 100100 returns rs AND rt, 100101 returns rs OR rt, 100110 returns rs XOR rt, and 100111 returns the inverse of (rs OR rt).
- R3: With opcode 000000, function 101010 compares rs and rt as signed values and 101011 compares them as unsigned values. Both return 32'd1 when rs is less than rt and 32'd0 otherwise.
- R4: Opcodes 001000 and 001001 return rs plus the sign-extended immediate from bits 15:0. Opcode 001010 returns 1 when rs is less than the sign-extended immediate, comparing signed. Opcode 001011 sign-extends the immediate and then compares unsigned.
- R5: Opcodes 001100, 001101 and 001110 AND, OR and XOR rs with the immediate zero-extended to 32 bits.
- R6: Opcode 001111 returns the 16-bit immediate in bits 31:16 and zeros in bits 15:0. The value of rs is ignored.
- R7: With opcode 000000, function 000000 shifts rt left, 000010 shifts rt right logically and 000011 shifts rt right arithmetically (copying bit 31). The distance is taken from bits 10:6 of the instruction.
- R8: With opcode 000000, functions 000100, 000110 and 000111 perform the same three shifts on rt. The distance is taken from bits 4:0 of rs, and the upper bits of rs are ignored.
- R9: For opcode 000000, the destination output equals instruction bits 15:11. For the immediate opcodes it equals instruction bits 20:16.
- R10: Any other opcode, or any other function code under opcode 000000, drives illegal high and forces the result and destination to zero. Recognised encodings drive illegal low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| rs_val | input | 32 | First source register value |
| rt_val | input | 32 | Second source register value |
| result | output | 32 | Computed value |
| dest | output | 5 | Index of register to write |
| illegal | output | 1 | Encoding not implemented by this unit |

## Verification
The hardest cases to reach from the ports are the sign-sensitive boundaries. One is the unsigned immediate compare against a sign-extended immediate near 0xFFFF. Others are arithmetic right shifts of negative values by 31, and variable shifts where rs carries junk above bit 4. Uniformly random operands almost never land on these edges. The stimulus therefore draws opcodes and function codes from the legal lists and mixes in random illegal codes. It also biases operands towards the extremes 0, 1, all-ones, 0x7FFFFFFF and 0x80000000. Directed words cover each boundary explicitly.

// File: rtl/int_alu_shift.sv
module int_alu_shift (
  input  logic [31:0] instr,
  input  logic [31:0] rs_val,
  input  logic [31:0] rt_val,
  output logic [31:0] result,
  output logic [4:0]  dest,
  output logic        illegal
);
  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_ADDIU = 6'b001001;
  localparam logic [5:0] OP_SLTI  = 6'b001010;
  localparam logic [5:0] OP_SLTIU = 6'b001011;
  localparam logic [5:0] OP_ANDI  = 6'b001100;
  localparam logic [5:0] OP_ORI   = 6'b001101;
  localparam logic [5:0] OP_XORI  = 6'b001110;
  localparam logic [5:0] OP_LUI   = 6'b001111;

  localparam logic [5:0] FN_SLL  = 6'b000000;
  localparam logic [5:0] FN_SRL  = 6'b000010;
  localparam logic [5:0] FN_SRA  = 6'b000011;
  localparam logic [5:0] FN_SLLV = 6'b000100;
  localparam logic [5:0] FN_SRLV = 6'b000110;
  localparam logic [5:0] FN_SRAV = 6'b000111;
  localparam logic [5:0] FN_ADD  = 6'b100000;
  localparam logic [5:0] FN_ADDU = 6'b100001;
  localparam logic [5:0] FN_SUB  = 6'b100010;
  localparam logic [5:0] FN_SUBU = 6'b100011;
  localparam logic [5:0] FN_AND  = 6'b100100;
  localparam logic [5:0] FN_OR   = 6'b100101;
  localparam logic [5:0] FN_XOR  = 6'b100110;
  localparam logic [5:0] FN_NOR  = 6'b100111;
  localparam logic [5:0] FN_SLT  = 6'b101010;
  localparam logic [5:0] FN_SLTU = 6'b101011;

  wire [5:0]  opc  = instr[31:26];
  wire [5:0]  fn   = instr[5:0];
  wire [4:0]  sa   = instr[10:6];
  wire [15:0] imm  = instr[15:0];
  wire [31:0] simm = {{16{imm[15]}}, imm};
  wire [31:0] zimm = {16'b0, imm};
  wire [4:0]  vamt = rs_val[4:0];

  logic unused_fields;
  assign unused_fields = ^instr[25:21];

  logic [31:0] res;
  logic [4:0]  dst;
  logic        bad;

  always_comb begin
    res = '0;
    dst = instr[20:16];
    bad = 1'b0;
    case (opc)
      OP_REG: begin
        dst = instr[15:11];
        case (fn)
          FN_ADD, FN_ADDU: res = rs_val + rt_val;
          FN_SUB, FN_SUBU: res = rs_val - rt_val;
          FN_AND:  res = rs_val & rt_val;
          FN_OR:   res = rs_val | rt_val;
          FN_XOR:  res = rs_val ^ rt_val;
          FN_NOR:  res = ~(rs_val | rt_val);
          FN_SLT:  res = {31'b0, $signed(rs_val) < $signed(rt_val)};
          FN_SLTU: res = {31'b0, rs_val < rt_val};
          FN_SLL:  res = rt_val << sa;
          FN_SRL:  res = rt_val >> sa;
          FN_SRA:  res = $unsigned($signed(rt_val) >>> sa);
          FN_SLLV: res = rt_val << vamt;
          FN_SRLV: res = rt_val >> vamt;
          FN_SRAV: res = $unsigned($signed(rt_val) >>> vamt);
          default: bad = 1'b1;
        endcase
      end
      OP_ADDI, OP_ADDIU: res = rs_val + simm;
      OP_SLTI:  res = {31'b0, $signed(rs_val) < $signed(simm)};
      OP_SLTIU: res = {31'b0, rs_val < simm};
      OP_ANDI:  res = rs_val & zimm;
      OP_ORI:   res = rs_val | zimm;
      OP_XORI:  res = rs_val ^ zimm;
      OP_LUI:   res = {imm, 16'b0};
      default:  bad = 1'b1;
    endcase
    if (bad) begin
      res = '0;
      dst = '0;
    end
  end

  assign result  = res;
  assign dest    = dst;
  assign illegal = bad;

  always_comb begin
    if (illegal)
      assert_illegal_quiet_R10: assert (result == 32'b0 && dest == 5'b0);
    if (!illegal && opc == OP_REG)
      assert_reg_dest_R9: assert (dest == instr[15:11]);
    if (!illegal && opc != OP_REG)
      assert_imm_dest_R9: assert (dest == instr[20:16]);
    if (opc == OP_LUI)
      assert_lui_low_zero_R6: assert (result[15:0] == 16'b0 && result[31:16] == imm);
    if (opc == OP_SLTI || opc == OP_SLTIU || (opc == OP_REG && (fn == FN_SLT || fn == FN_SLTU)))
      assert_slt_boolean_R3: assert (result[31:1] == 31'b0);
    if (opc == OP_REG && fn == FN_SRA)
      assert_sra_sign_R7: assert (result[31] == rt_val[31]);
    if (opc == OP_REG && fn == FN_SRLV && vamt != 5'd0)
      assert_srlv_top_zero_R8: assert (result[31] == 1'b0);
    if (opc == OP_ANDI)
      assert_andi_upper_zero_R5: assert (result[31:16] == 16'b0);
  end
endmodule

// File: tb/sim_int_alu_shift.sv
module sim_int_alu_shift;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instr = '0, rs_val = '0, rt_val = '0;
  logic [31:0] result;
  logic [4:0]  dest;
  logic        illegal;

  int checks = 0, failures = 0;
  bit finished = 0;

  int_alu_shift u0 (.instr(instr), .rs_val(rs_val), .rt_val(rt_val),
                    .result(result), .dest(dest), .illegal(illegal));

  function automatic logic [37:0] model(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic [5:0] op = w[31:26];
    logic [5:0] f  = w[5:0];
    logic [31:0] se = {{16{w[15]}}, w[15:0]};
    logic [31:0] ze = {16'h0, w[15:0]};
    logic [31:0] r;
    int sh;
    r = 0;
    if (op == 6'd0) begin
      sh = (f[2]) ? int'(a[4:0]) : int'(w[10:6]);
      if (f == 6'h20 || f == 6'h21) r = a + b;
      else if (f == 6'h22 || f == 6'h23) r = a - b;
      else if (f == 6'h24) r = a & b;
      else if (f == 6'h25) r = a | b;
      else if (f == 6'h26) r = a ^ b;
      else if (f == 6'h27) r = ~a & ~b;
      else if (f == 6'h2a) r = ((a[31] && !b[31]) || (a[31] == b[31] && a < b)) ? 1 : 0;
      else if (f == 6'h2b) r = (a < b) ? 1 : 0;
      else if (f == 6'h00 || f == 6'h04) r = b << sh;
      else if (f == 6'h02 || f == 6'h06) r = b >> sh;
      else if (f == 6'h03 || f == 6'h07) begin
        r = b >> sh;
        for (int i = 0; i < 32; i++) if (i >= 32 - sh && b[31]) r[i] = 1'b1;
      end
      else return {1'b1, 5'd0, 32'd0};
      return {1'b0, w[15:11], r};
    end
    case (op)
      6'h08, 6'h09: r = a + se;
      6'h0a: r = ((a[31] && !se[31]) || (a[31] == se[31] && a < se)) ? 1 : 0;
      6'h0b: r = (a < se) ? 1 : 0;
      6'h0c: r = a & ze;
      6'h0d: r = a | ze;
      6'h0e: r = a ^ ze;
      6'h0f: r = w[15:0] * 32'h10000;
      default: return {1'b1, 5'd0, 32'd0};
    endcase
    return {1'b0, w[20:16], r};
  endfunction

  function automatic string tag(input logic [31:0] w);
    logic [5:0] op = w[31:26];
    logic [5:0] f  = w[5:0];
    if (op == 0) begin
      if (f >= 6'h20 && f <= 6'h23) return "R1";
      if (f >= 6'h24 && f <= 6'h27) return "R2";
      if (f == 6'h2a || f == 6'h2b) return "R3";
      if (f == 6'h00 || f == 6'h02 || f == 6'h03) return "R7";
      if (f == 6'h04 || f == 6'h06 || f == 6'h07) return "R8";
      return "R10";
    end
    if (op >= 6'h08 && op <= 6'h0b) return "R4";
    if (op >= 6'h0c && op <= 6'h0e) return "R5";
    if (op == 6'h0f) return "R6";
    return "R10";
  endfunction

  task automatic apply(input logic [31:0] w, input logic [31:0] a, input logic [31:0] b);
    logic [37:0] exp;
    @(negedge clk);
    instr = w; rs_val = a; rt_val = b;
    #5;
    exp = model(w, a, b);
    checks++;
    if ({illegal, dest, result} !== exp) begin
      failures++;
      $display("FAIL %s instr=%h rs=%h rt=%h: got ill=%0d dest=%0d res=%h, want ill=%0d dest=%0d res=%h",
               tag(w), w, a, b, illegal, dest, result, exp[37], exp[36:32], exp[31:0]);
    end
    checks++;
    if (!exp[37] && dest !== (w[31:26] == 0 ? w[15:11] : w[20:16])) begin
      failures++;
      $display("FAIL R9 dest got %0d expected %0d", dest, (w[31:26] == 0 ? w[15:11] : w[20:16]));
    end
  endtask

  function automatic logic [31:0] pick_val();
    case ($urandom_range(0, 7))
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'hFFFFFFFF;
      3: return 32'h7FFFFFFF;
      4: return 32'h80000000;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [31:0] rtype(input logic [5:0] f, input logic [4:0] sa);
    return {6'd0, 5'($urandom), 5'($urandom), 5'($urandom), sa, f};
  endfunction

  function automatic logic [31:0] itype(input logic [5:0] op, input logic [15:0] imm);
    return {op, 5'($urandom), 5'($urandom), imm};
  endfunction

  logic [5:0] rfns [16] = '{6'h20,6'h21,6'h22,6'h23,6'h24,6'h25,6'h26,6'h27,
                            6'h2a,6'h2b,6'h00,6'h02,6'h03,6'h04,6'h06,6'h07};

  initial begin
    #2_000_000;
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // zero inputs: shift-left by 0 of 0, destination 0
    apply(32'h0, 32'h0, 32'h0);
    // R1 wraparound, add and add-unsigned identical
    apply({6'd0,5'd1,5'd2,5'd3,5'd0,6'h20}, 32'h7FFFFFFF, 32'h1);
    apply({6'd0,5'd1,5'd2,5'd3,5'd0,6'h21}, 32'h7FFFFFFF, 32'h1);
    apply({6'd0,5'd1,5'd2,5'd4,5'd0,6'h23}, 32'h0, 32'h1);
    // R2 nor
    apply({6'd0,5'd1,5'd2,5'd5,5'd0,6'h27}, 32'h0F0F0000, 32'h000000F0);
    // R3 signed vs unsigned
    apply({6'd0,5'd1,5'd2,5'd6,5'd0,6'h2a}, 32'hFFFFFFFF, 32'h1);
    apply({6'd0,5'd1,5'd2,5'd6,5'd0,6'h2b}, 32'hFFFFFFFF, 32'h1);
    // R4 unsigned-immediate compare after sign extension
    apply({6'h0b,5'd1,5'd7,16'hFFFF}, 32'hFFFFFFFE, 32'h0);
    apply({6'h0a,5'd1,5'd7,16'h8000}, 32'hFFFF0000, 32'h0);
    apply({6'h08,5'd1,5'd7,16'hFFFF}, 32'h5, 32'h0);
    // R5 zero extension
    apply({6'h0d,5'd1,5'd8,16'h8001}, 32'h0, 32'h0);
    // R6 upper immediate ignores rs
    apply({6'h0f,5'd1,5'd9,16'hBEEF}, 32'hFFFFFFFF, 32'h0);
    // R7 arithmetic right by 31
    apply({6'd0,5'd0,5'd2,5'd10,5'd31,6'h03}, 32'h0, 32'h80000000);
    apply({6'd0,5'd0,5'd2,5'd10,5'd4,6'h02}, 32'h0, 32'h80000000);
    // R8 variable shift ignores rs above bit 4
    apply({6'd0,5'd1,5'd2,5'd11,5'd0,6'h07}, 32'hFFFFFFE5, 32'h80000000);
    apply({6'd0,5'd1,5'd2,5'd11,5'd0,6'h04}, 32'h00000120, 32'h1);
    // R10 illegal function and opcode
    apply({6'd0,5'd1,5'd2,5'd12,5'd0,6'h01}, 32'h1, 32'h2);
    apply({6'h02,26'h3FFFFFF}, 32'h1, 32'h2);
    apply({6'h23,5'd1,5'd2,16'h0010}, 32'h1, 32'h2);
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] w;
      case ($urandom_range(0, 3))
        0, 1: w = rtype(rfns[$urandom_range(0, 15)], 5'($urandom));
        2: w = itype(6'($urandom_range(8, 15)), 16'($urandom));
        default: w = $urandom;
      endcase
      apply(w, pick_val(), pick_val());
    end
    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule